// File: doc/BRIEF.md
# Folded Memory Address Decoder

This block turns a word address into the row-select and column-select lines for a memory of 2^n words of 2^m bits. The array is stored folded: each physical row holds 2^k words side by side, so the array has 2^(n-k) rows and 2^(m+k) bit columns. The upper n-k address bits go to a row decoder. The lower k bits go to a column decoder, and a column multiplexer uses that decoder's output to pick one word out of the wide physical row.

The row decoder is built in two levels. The row address bits are taken two at a time, and each pair is predecoded into a group of four lines with exactly one line active. When the number of row bits is odd, the last single bit forms a group of two lines. Each row line is then the AND of one line from every group.

A behavioural storage array sits behind the decoders so that reads and writes can be checked end to end. Read data is registered. A write changes only the addressed word within its row. The default organization is 1024 words of 32 bits, stored as 256 rows of 128 columns (32 kbit).

Top module: `folded_sram_decode`

## Requirements
- R1: While `en` is 1, exactly one bit of `wordline` is set, and it is bit `addr[N_ADDR-1:K_FOLD]`.
- R2: While `en` is 1, exactly one bit of `col_sel` is set, and it is bit `addr[K_FOLD-1:0]`.
- R3: While `en` is 0, every bit of `wordline` and of `col_sel` is 0, whatever the address.
- R4: Row bits are predecoded in pairs, starting from the least significant row bit. Each pair gives a 1-of-4 group, and a leftover single bit gives a 1-of-2 group. While `en` is 1, every group has exactly one active line, and every row line is correct across the whole row range.
- R5: A cycle with `en`=1 and `wr_en`=0 places the stored word at `addr` on `rdata` after the next rising clock edge.
- R6: A cycle with `en`=1 and `wr_en`=1 stores `wdata` into the word at `addr` only. The other 2^k-1 words that share its physical row keep their values.
- R7: `rdata` keeps its value through write cycles and through cycles with `en`=0.
- R8: After reset, `rdata` reads 0.
- R9: With the default parameters (N_ADDR=10, M_DATA_LOG2=5, K_FOLD=2), the array has 256 rows of 128 columns. Address 1023 selects row 255 and column select 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Access enable; when 0, every select line is inactive |
| wr_en | input | 1 | 1 = write, 0 = read (only meaningful while `en` is 1) |
| addr | input | N_ADDR | Word address: upper bits select the row, lower K_FOLD bits select the word within the row |
| wdata | input | 2^M_DATA_LOG2 | Write data |
| wordline | output | 2^(N_ADDR-K_FOLD) | Decoded row selects, one-hot while enabled |
| col_sel | output | 2^K_FOLD | Decoded column-group selects, one-hot while enabled |
| rdata | output | 2^M_DATA_LOG2 | Registered read data |

## Verification
The hardest case to reach is a write that disturbs the other words folded into the same physical row. Catching it needs all four neighbours to hold known, distinct values, then a write to one of them, then reads of the other three before anything else touches that row. The stimulus first fills every address with a value derived from that address. It then runs targeted write-then-read-neighbours sequences across several rows. Full sweeps of all 256 row indices drive every predecode group through every one of its lines.

// File: rtl/fdec_pkg.sv
package fdec_pkg;

  // Number of predecode groups for a given count of row address bits.
  function automatic int unsigned pre_groups(input int unsigned row_bits);
    return (row_bits + 1) / 2;
  endfunction

  // Total predecoded lines: 4 per full pair, 2 for a trailing single bit.
  function automatic int unsigned pre_width(input int unsigned row_bits);
    return (row_bits % 2 == 1) ? 4 * (row_bits / 2) + 2 : 4 * (row_bits / 2);
  endfunction

endpackage

// File: rtl/fdec_predec.sv
module fdec_predec #(
  parameter  int unsigned IN_BITS = 2,
  localparam int unsigned LINES   = 1 << IN_BITS
) (
  input  logic               en,
  input  logic [IN_BITS-1:0] sel,
  output logic [LINES-1:0]   lines
);

  // One line per code value of the address slice, gated by the enable.
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lines[i] = en && (sel == IN_BITS'(i));
  end

endmodule

// File: rtl/fdec_row_and.sv
module fdec_row_and #(
  parameter int unsigned ROW_BITS = 8,
  parameter int unsigned GROUPS   = 4,
  parameter int unsigned PRE_W    = 16,
  parameter int unsigned ROWS     = 256
) (
  input  logic [PRE_W-1:0] pre_lines,
  output logic [ROWS-1:0]  wordline
);

  // Each row takes one line per group, chosen by that row's own index bits.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [GROUPS-1:0] term;
    for (genvar g = 0; g < GROUPS; g++) begin : g_term
      localparam int unsigned PICK = (r >> (2 * g)) & 3;
      assign term[g] = pre_lines[4 * g + PICK];
    end
    assign wordline[r] = &term;
  end

endmodule

// File: rtl/fdec_col_decoder.sv
module fdec_col_decoder #(
  parameter  int unsigned K_FOLD  = 2,
  localparam int unsigned COL_SEL = 1 << K_FOLD
) (
  input  logic              en,
  input  logic [K_FOLD-1:0] sel,
  output logic [COL_SEL-1:0] col_sel
);

  for (genvar c = 0; c < COL_SEL; c++) begin : g_col
    assign col_sel[c] = en && (sel == K_FOLD'(c));
  end

endmodule

// File: rtl/fdec_array.sv
module fdec_array #(
  parameter  int unsigned ROWS    = 256,
  parameter  int unsigned COL_SEL = 4,
  parameter  int unsigned WORD_W  = 32,
  localparam int unsigned ROW_W   = WORD_W * COL_SEL
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               wr_en,
  input  logic [ROWS-1:0]    wordline,
  input  logic [COL_SEL-1:0] col_sel,
  input  logic [WORD_W-1:0]  wdata,
  output logic [WORD_W-1:0]  rdata
);

  logic [ROW_W-1:0]  mem [ROWS];
  logic [ROW_W-1:0]  row_bus;
  logic [WORD_W-1:0] word_mux;
  logic [WORD_W-1:0] rdata_d;
  logic [WORD_W-1:0] rdata_q;
  logic              wr_go;
  logic              rd_go;

  assign wr_go = en & wr_en;
  assign rd_go = en & ~wr_en;

  // Storage: only the slice under both the active row and the active column group changes.
  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COL_SEL; c++) begin
        if (wr_go && wordline[r] && col_sel[c]) begin
          mem[r][c*WORD_W +: WORD_W] <= wdata;
        end
      end
    end
  end

  // Row read-out and column multiplexer, both steered by the decoded selects.
  always_comb begin
    row_bus = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (wordline[r]) row_bus = row_bus | mem[r];
    end
    word_mux = '0;
    for (int c = 0; c < COL_SEL; c++) begin
      if (col_sel[c]) word_mux = word_mux | row_bus[c*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    rdata_d = rd_go ? word_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/folded_sram_decode.sv
module folded_sram_decode
  import fdec_pkg::*;
#(
  parameter  int unsigned N_ADDR      = 10,
  parameter  int unsigned M_DATA_LOG2 = 5,
  parameter  int unsigned K_FOLD      = 2,
  localparam int unsigned WORD_W      = 1 << M_DATA_LOG2,
  localparam int unsigned ROW_BITS    = N_ADDR - K_FOLD,
  localparam int unsigned ROWS        = 1 << ROW_BITS,
  localparam int unsigned COL_SEL     = 1 << K_FOLD
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               wr_en,
  input  logic [N_ADDR-1:0]  addr,
  input  logic [WORD_W-1:0]  wdata,
  output logic [ROWS-1:0]    wordline,
  output logic [COL_SEL-1:0] col_sel,
  output logic [WORD_W-1:0]  rdata
);

  localparam int unsigned GROUPS = pre_groups(ROW_BITS);
  localparam int unsigned PRE_W  = pre_width(ROW_BITS);

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [PRE_W-1:0] pre_lines;

  // Reset asserts at once and is released two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  // Row predecode: pairs of row bits, lowest first; an odd bit out becomes 1-of-2.
  for (genvar g = 0; g < GROUPS; g++) begin : g_pre
    localparam int unsigned GB = (2 * g + 2 <= ROW_BITS) ? 2 : 1;
    fdec_predec #(.IN_BITS(GB)) u_pre (
      .en   (en),
      .sel  (addr[K_FOLD + 2*g +: GB]),
      .lines(pre_lines[4*g +: (1 << GB)])
    );
  end

  fdec_row_and #(
    .ROW_BITS(ROW_BITS),
    .GROUPS  (GROUPS),
    .PRE_W   (PRE_W),
    .ROWS    (ROWS)
  ) u_rows (
    .pre_lines(pre_lines),
    .wordline (wordline)
  );

  fdec_col_decoder #(.K_FOLD(K_FOLD)) u_cols (
    .en     (en),
    .sel    (addr[K_FOLD-1:0]),
    .col_sel(col_sel)
  );

  fdec_array #(
    .ROWS   (ROWS),
    .COL_SEL(COL_SEL),
    .WORD_W (WORD_W)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en      (en),
    .wr_en   (wr_en),
    .wordline(wordline),
    .col_sel (col_sel),
    .wdata   (wdata),
    .rdata   (rdata)
  );

endmodule

// File: rtl/fdec_checker.sv
module fdec_checker #(
  parameter int unsigned N_ADDR   = 10,
  parameter int unsigned K_FOLD   = 2,
  parameter int unsigned ROW_BITS = 8,
  parameter int unsigned ROWS     = 256,
  parameter int unsigned COL_SEL  = 4,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned GROUPS   = 4,
  parameter int unsigned PRE_W    = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               wr_en,
  input logic [N_ADDR-1:0]  addr,
  input logic [ROWS-1:0]    wordline,
  input logic [COL_SEL-1:0] col_sel,
  input logic [WORD_W-1:0]  rdata,
  input logic [PRE_W-1:0]   pre_lines
);

  p_wl_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> $onehot(wordline));

  p_wl_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> wordline[addr[N_ADDR-1:K_FOLD]]);

  p_col_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ($onehot(col_sel) && col_sel[addr[K_FOLD-1:0]]));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (wordline == '0 && col_sel == '0 && pre_lines == '0));

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int unsigned USED = (2 * g + 2 <= ROW_BITS) ? 4 : 2;
    p_group_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> $onehot(pre_lines[4*g +: USED]));
  end

  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && !wr_en) |=> $stable(rdata));

endmodule

bind folded_sram_decode fdec_checker #(
  .N_ADDR  (N_ADDR),
  .K_FOLD  (K_FOLD),
  .ROW_BITS(ROW_BITS),
  .ROWS    (ROWS),
  .COL_SEL (COL_SEL),
  .WORD_W  (WORD_W),
  .GROUPS  (GROUPS),
  .PRE_W   (PRE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .wr_en    (wr_en),
  .addr     (addr),
  .wordline (wordline),
  .col_sel  (col_sel),
  .rdata    (rdata),
  .pre_lines(pre_lines)
);

// File: tb/sim_folded_sram_decode.sv
module sim_folded_sram_decode;

  localparam int N     = 10;
  localparam int MLOG  = 5;
  localparam int K     = 2;
  localparam int WW    = 1 << MLOG;
  localparam int ROWS  = 1 << (N - K);
  localparam int CS    = 1 << K;
  localparam int WORDS = 1 << N;

  logic            clk;
  logic            rst_n;
  logic            en;
  logic            wr_en;
  logic [N-1:0]    addr;
  logic [WW-1:0]   wdata;
  logic [ROWS-1:0] wordline;
  logic [CS-1:0]   col_sel;
  logic [WW-1:0]   rdata;

  folded_sram_decode #(.N_ADDR(N), .M_DATA_LOG2(MLOG), .K_FOLD(K)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .wordline(wordline), .col_sel(col_sel), .rdata(rdata)
  );

  int compared = 0;
  int mismatched = 0;
  logic [WW-1:0] ref_mem [WORDS];
  logic [WW-1:0] exp_rd;
  string rd_tag;
  string note;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [WW-1:0] seed_val(input int a);
    return WW'(a) * 32'h9E37_79B1 ^ 32'h5A5A_0F0F;
  endfunction

  task automatic fail(input string tag, input string detail);
    mismatched++;
    $display("FAIL %s %s %s", tag, note, detail);
  endtask

  // One access per call: check the last registered result, drive, check the decoders.
  task automatic step(input logic e, input logic w, input int a, input logic [WW-1:0] d);
    logic [ROWS-1:0] exp_wl;
    logic [CS-1:0]   exp_cs;
    logic [ROWS-1:0] one_wl;
    logic [CS-1:0]   one_cs;
    @(negedge clk);
    compared++;
    if (rdata !== exp_rd)
      fail(rd_tag, $sformatf("rdata actual %h expected %h", rdata, exp_rd));
    en = e; wr_en = w; addr = N'(a); wdata = d;
    #1;
    one_wl = 1;
    one_cs = 1;
    exp_wl = e ? (one_wl << (a >> K)) : '0;
    exp_cs = e ? (one_cs << (a % CS)) : '0;
    compared++;
    if (wordline !== exp_wl)
      fail(e ? "R1" : "R3", $sformatf("wordline actual %h expected %h", wordline, exp_wl));
    compared++;
    if (col_sel !== exp_cs)
      fail(e ? "R2" : "R3", $sformatf("col_sel actual %b expected %b", col_sel, exp_cs));
    if (e && !w) begin
      exp_rd = ref_mem[a];
      rd_tag = "R5";
    end else begin
      rd_tag = "R7";
    end
    if (e && w) ref_mem[a] = d;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog run did not finish");
    summary();
    $finish;
  end

  initial begin
    en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    exp_rd = '0; rd_tag = "R8"; note = "reset";
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R8: read data is zero after reset; idle cycles leave it there (R3, R7)
    note = "R8";
    rd_tag = "R8";
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, i * 77, '0);

    // Fill every word with a value tied to its address
    note = "fill";
    for (int a = 0; a < WORDS; a++) step(1'b1, 1'b1, a, seed_val(a));

    // R4, R5: ascending read sweep covers every row and every predecode line
    note = "R4 sweep";
    for (int a = 0; a < WORDS; a++) step(1'b1, 1'b0, a, '0);

    // R9: the top word lands on row 255, column select 3
    note = "R9";
    step(1'b1, 1'b0, WORDS - 1, '0);
    step(1'b0, 1'b0, 0, '0);

    // R3, R7: disabled cycles with busy address and write inputs
    note = "R3 idle";
    for (int i = 0; i < 16; i++) step(1'b0, i[0], (i * 131) % WORDS, 32'hDEAD_0000 | i);

    // R6: write one word, then read its three row neighbours and itself
    note = "R6";
    for (int t = 0; t < 24; t++) begin
      int base;
      int pos;
      base = ((t * 37) % ROWS) * CS;
      pos  = t % CS;
      step(1'b1, 1'b1, base + pos, ~seed_val(base + pos) ^ t);
      for (int j = 1; j < CS; j++) step(1'b1, 1'b0, base + ((pos + j) % CS), '0);
      step(1'b1, 1'b0, base + pos, '0);
    end

    // R7: a write directly after a read leaves the read result in place
    note = "R7";
    step(1'b1, 1'b0, 5, '0);
    step(1'b1, 1'b1, 5, 32'h1234_5678);
    step(1'b0, 1'b0, 5, '0);
    step(1'b1, 1'b0, 5, '0);

    // Mixed random traffic, descending and scattered addresses
    note = "random";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom);
      step((r % 8) != 0, (r % 3) == 0, int'($urandom % WORDS), $urandom);
    end
    step(1'b0, 1'b0, 0, '0);

    summary();
    $finish;
  end

endmodule